// File: doc/BRIEF.md
# Pipelined 64-bit Integer Multiplier

This block is the multiply lane of a 64-bit execute stage. Each cycle it may accept one operation. An operation carries two 65-bit operands, a 2-bit selector that picks the part of the product to return, a 5-bit destination register number and a flag that asks for a condition-field update. Sign or zero extension of the operands is done before the block. Bit 64 of each operand repeats bit 63 for a signed form and is zero for an unsigned form. The block therefore always does one signed 65x65 multiply, whether the form is signed or unsigned.

After a fixed latency the result leaves as a writeback record. The record holds the register write enable, the destination number, the 64-bit result, and an optional 32-bit condition word. The condition word carries a negative/positive/zero nibble in bits 31..28. The kinds of operation are:
- low-half 64-bit multiplies;
- high-half 64-bit multiplies;
- high-word 32-bit multiplies;
- multiplies by a sign-extended 16-bit immediate, which use the low-half selector.

There are no stalls and no flushes. Only reset empties the pipe.

Top module: `mul_pipe`

## Requirements
- R1: `out_valid` rises after exactly LAT rising clock edges (default 4), counting the edge that samples `in_valid` high as the first. It stays high for one cycle per accepted operation.
- R2: A new operation can be accepted on every cycle. Each operation's selector, record flag and destination travel with its data, so back-to-back results come out in order, one per cycle.
- R3: Selector code 2'b00 returns bits 63..0 of the signed 65x65 product. Code 2'b11 behaves the same as 2'b00.
- R4: Selector code 2'b01 returns bits 127..64 of the signed 65x65 product. Unsigned operands (bit 64 = 0) give the unsigned high half. Signed operands give the signed high half.
- R5: Selector code 2'b10 takes the product of 32-bit-extended operands and returns its bits 63..32 in both bits 63..32 and bits 31..0 of the result.
- R6: `out_wen` equals `out_valid`. `out_dest` equals the destination number given with the operation.
- R7: `out_cr_wen` is high only when `out_valid` is high and the operation's record flag was set.
- R8: When `out_cr_wen` is high, `out_cr_data` holds a nibble in bits 31..28 and zero in all other bits. The nibble is 4'h8 when result bit 63 is set, 4'h2 when the result is zero, and 4'h4 otherwise. When `out_cr_wen` is low, `out_cr_data` is zero.
- R9: A multiply by a 16-bit immediate is given as the immediate sign-extended to 65 bits, with selector 2'b00, and returns the low 64 bits of the signed product.
- R10: `rst_n` low at a clock edge clears every operation in flight. After reset, `out_valid` and `out_cr_wen` stay low until a newly accepted operation reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Product selector: 00 low64, 01 high64, 10 high32, 11 as 00 |
| in_dest | input | 5 | Destination register number |
| in_rec | input | 1 | Request a condition-field update |
| in_a | input | 65 | First operand, extended to 65 bits |
| in_b | input | 65 | Second operand, extended to 65 bits |
| out_valid | output | 1 | Writeback record present |
| out_wen | output | 1 | Register write enable |
| out_dest | output | 5 | Register number to write |
| out_data | output | 64 | Selected result |
| out_cr_wen | output | 1 | Condition-field write enable |
| out_cr_data | output | 32 | Condition word, nibble in bits 31..28 |

## Verification
In the same cycle, the block can take in a new operation at the input and retire an older one at the output. Because operations overlap, one operation's record flag, destination and selector may sit in a stage next to a different operation's data. The bench provokes this by driving a whole vector table back to back, one operation per cycle. In that stream, rows with and without the record flag are mixed, and so are the three selectors. Each retiring record is judged against the row that was issued LAT cycles earlier, one field at a time. A reset that lands while operations are in flight is also checked: none of them may come out afterwards.

// File: rtl/mul_pipe.sv
module mul_pipe #(
  parameter int LAT  = 4,
  parameter int XLEN = 64,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic [RW-1:0]   in_dest,
  input  logic            in_rec,
  input  logic [XLEN:0]   in_a,
  input  logic [XLEN:0]   in_b,
  output logic            out_valid,
  output logic            out_wen,
  output logic [RW-1:0]   out_dest,
  output logic [XLEN-1:0] out_data,
  output logic            out_cr_wen,
  output logic [31:0]     out_cr_data
);
  // LAT must be at least 2: one product stage plus the output stage.
  localparam int OW = XLEN + 1;
  localparam int PW = 2 * XLEN;
  localparam int HW = XLEN / 2;
  localparam int NS = LAT - 1;
  localparam logic [1:0] SEL_HI = 2'd1;
  localparam logic [1:0] SEL_HW = 2'd2;

  logic [LAT-1:0]  v_q;
  logic [PW-1:0]   prod_q [NS];
  logic [1:0]      op_q   [NS];
  logic [RW-1:0]   dst_q  [NS];
  logic            rec_q  [NS];

  logic [PW-1:0]   a_x, b_x, prod_c;
  logic [XLEN-1:0] res_c;
  logic [3:0]      nib_c;
  logic [1:0]      op_o;
  logic            rec_o;
  logic [31:0]     cr_q;

  assign a_x    = {{(PW-OW){in_a[OW-1]}}, in_a};
  assign b_x    = {{(PW-OW){in_b[OW-1]}}, in_b};
  assign prod_c = a_x * b_x;

  always_ff @(posedge clk) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[LAT-2:0], in_valid};
    prod_q[0] <= prod_c;
    op_q[0]   <= in_op;
    dst_q[0]  <= in_dest;
    rec_q[0]  <= in_rec;
    for (int i = 1; i < NS; i++) begin
      prod_q[i] <= prod_q[i-1];
      op_q[i]   <= op_q[i-1];
      dst_q[i]  <= dst_q[i-1];
      rec_q[i]  <= rec_q[i-1];
    end
  end

  always_comb begin
    case (op_q[NS-1])
      SEL_HI:  res_c = prod_q[NS-1][PW-1:XLEN];
      SEL_HW:  res_c = {prod_q[NS-1][XLEN-1:HW], prod_q[NS-1][XLEN-1:HW]};
      default: res_c = prod_q[NS-1][XLEN-1:0];
    endcase
    if (res_c[XLEN-1])  nib_c = 4'h8;
    else if (res_c == '0) nib_c = 4'h2;
    else                nib_c = 4'h4;
  end

  always_ff @(posedge clk) begin
    out_data <= res_c;
    out_dest <= dst_q[NS-1];
    op_o     <= op_q[NS-1];
    rec_o    <= rec_q[NS-1];
    cr_q     <= {nib_c, 28'd0};
  end

  assign out_valid   = v_q[LAT-1];
  assign out_wen     = v_q[LAT-1];
  assign out_cr_wen  = v_q[LAT-1] & rec_o;
  assign out_cr_data = out_cr_wen ? cr_q : 32'd0;

  // In-flight tracker for the checks below
  logic [7:0] fly_q;
  always_ff @(posedge clk) begin
    if (!rst_n) fly_q <= 8'd0;
    else        fly_q <= fly_q + {7'd0, in_valid} - {7'd0, out_valid};
  end

  assert_fly_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fly_q <= 8'(LAT));
  assert_out_has_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fly_q != 8'd0);
  assert_cr_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_wen |-> out_valid && out_wen);
  assert_cr_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_wen |-> ($countones(out_cr_data[31:28]) == 1 && out_cr_data[27:0] == 28'd0));
  assert_cr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cr_wen && out_data == '0) |-> out_cr_data == 32'h2000_0000);
  assert_cr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_cr_wen |-> out_cr_data == 32'd0);
  assert_hw_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_o == SEL_HW) |-> out_data[XLEN-1:HW] == out_data[HW-1:0]);
  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_cr_wen);
endmodule

// File: tb/mul_pipe_bench.sv
module mul_pipe_bench;
  localparam int LAT = 4;
  localparam int N   = 13;

  logic        clk = 0, rst_n = 0, in_valid = 0, in_rec = 0;
  logic [1:0]  in_op = 0;
  logic [4:0]  in_dest = 0;
  logic [64:0] in_a = 0, in_b = 0;
  logic        out_valid, out_wen, out_cr_wen;
  logic [4:0]  out_dest;
  logic [63:0] out_data;
  logic [31:0] out_cr_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mul_pipe #(.LAT(LAT)) u_mul_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dest(in_dest), .in_rec(in_rec), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_wen(out_wen), .out_dest(out_dest),
    .out_data(out_data), .out_cr_wen(out_cr_wen), .out_cr_data(out_cr_data));

  localparam logic [1:0]  T_OP [N] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2,
                                       2'd0, 2'd0, 2'd1, 2'd3, 2'd0, 2'd1};
  localparam logic [64:0] T_A [N] = '{
    65'h0_0000_0000_0000_1000, 65'h1_FFFF_FFFF_FFFF_FFFF, 65'h0_FFFF_FFFF_FFFF_FFFF,
    65'h1_FFFF_FFFF_FFFF_FFFF, 65'h1_FFFF_FFFF_FFFF_FFFF, 65'h0_0000_0000_FFFF_FFFF,
    65'h1_FFFF_FFFF_FFFF_FFFF, 65'h0_0000_0000_0000_0007, 65'h0,
    65'h0_4000_0000_0000_0000, 65'h3, 65'h1_8000_0000_0000_0000, 65'h1_8000_0000_0000_0000};
  localparam logic [64:0] T_B [N] = '{
    65'h0_0000_0000_0000_1111, 65'h5, 65'h0_FFFF_FFFF_FFFF_FFFF,
    65'h1_FFFF_FFFF_FFFF_FFFF, 65'h5, 65'h0_0000_0000_FFFF_FFFF,
    65'h2, 65'h1_FFFF_FFFF_FFFF_FFF0, 65'h0_1234_5678_9ABC_DEF0,
    65'h4, 65'h4, 65'h1_FFFF_FFFF_FFFF_FFFF, 65'h1_FFFF_FFFF_FFFF_FFFF};
  localparam logic        T_REC [N] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0,
                                        1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [4:0]  T_DST [N] = '{5'd17, 5'd3, 5'd31, 5'd0, 5'd9, 5'd12, 5'd13,
                                        5'd21, 5'd5, 5'd7, 5'd30, 5'd1, 5'd2};
  localparam logic [63:0] T_EXP [N] = '{
    64'h0000_0000_0111_1000, 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFE,
    64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFE_FFFF_FFFE,
    64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF90, 64'h0,
    64'h1, 64'hC, 64'h8000_0000_0000_0000, 64'h0};
  localparam string T_REQ [N] = '{"R3", "R3", "R4", "R4", "R4", "R5", "R5",
                                  "R9", "R3", "R4", "R3", "R3", "R4"};

  function automatic logic [31:0] cr_of(logic [63:0] d);
    if (d[63])      return 32'h8000_0000;
    else if (d == 0) return 32'h2000_0000;
    else            return 32'h4000_0000;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(bit v, int k);
    in_valid = v;
    if (k >= 0) begin
      in_op = T_OP[k]; in_a = T_A[k]; in_b = T_B[k];
      in_rec = T_REC[k]; in_dest = T_DST[k];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && out_wen == 0, "R10 reset valid", {63'd0, out_valid}, 0);
    chk(out_cr_wen == 0, "R10 reset cr", {63'd0, out_cr_wen}, 0);
    rst_n = 1;

    // Back-to-back stream: issue and retire overlap (R2)
    for (int c = 0; c < N + LAT + 1; c++) begin
      int j;
      @(negedge clk);
      j = c - LAT;
      if (j >= 0 && j < N) begin
        chk(out_valid == 1, "R2 stream valid", {63'd0, out_valid}, 1);
        chk(out_wen == 1, "R6 wen", {63'd0, out_wen}, 1);
        chk(out_dest == T_DST[j], "R6 dest", {59'd0, out_dest}, {59'd0, T_DST[j]});
        chk(out_data == T_EXP[j], T_REQ[j], out_data, T_EXP[j]);
        chk(out_cr_wen == T_REC[j], "R7 cr_wen", {63'd0, out_cr_wen}, {63'd0, T_REC[j]});
        chk(out_cr_data == (T_REC[j] ? cr_of(T_EXP[j]) : 32'd0), "R8 cr_data",
            {32'd0, out_cr_data}, {32'd0, (T_REC[j] ? cr_of(T_EXP[j]) : 32'd0)});
      end else begin
        chk(out_valid == 0 && out_cr_wen == 0, "R1 idle", {63'd0, out_valid}, 0);
      end
      if (c < N) drive(1, c); else drive(0, -1);
    end

    // Latency and single-cycle pulse (R1)
    @(negedge clk);
    drive(1, 0);
    k = 0;
    @(negedge clk);
    drive(0, -1);
    k = 1;
    while (!out_valid && k < 20) begin
      @(negedge clk);
      k++;
    end
    chk(k == LAT, "R1 latency", 64'(k), 64'(LAT));
    @(negedge clk);
    chk(out_valid == 0, "R1 pulse width", {63'd0, out_valid}, 0);

    // Gap between operations: bubble stays a bubble (R2)
    drive(1, 5);
    @(negedge clk); drive(0, -1);
    @(negedge clk); drive(1, 1);
    @(negedge clk); drive(0, -1);
    repeat (LAT - 3) @(negedge clk);
    chk(out_valid == 1 && out_data == T_EXP[5], "R2 gap first", out_data, T_EXP[5]);
    @(negedge clk);
    chk(out_valid == 0, "R2 gap bubble", {63'd0, out_valid}, 0);
    @(negedge clk);
    chk(out_valid == 1 && out_dest == T_DST[1], "R2 gap second", {59'd0, out_dest}, {59'd0, T_DST[1]});
    chk(out_cr_data == 32'h8000_0000, "R8 negative", {32'd0, out_cr_data}, 64'h8000_0000);

    // Reset with operations in flight (R10)
    @(negedge clk); drive(1, 0);
    @(negedge clk); drive(1, 2);
    @(negedge clk); drive(0, -1); rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int c = 0; c < LAT + 2; c++) begin
      chk(out_valid == 0 && out_cr_wen == 0, "R10 flushed", {63'd0, out_valid}, 0);
      @(negedge clk);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule